// File: doc/BRIEF.md
# Cache Access Statistics Counters

This block sits beside a cache controller and keeps integer performance counts of its traffic. Every cycle the controller may report one access through a strobe, tagged as a hit or a miss and as a read or a write. The block sorts each reported access into one of four saturating counters: read hits, write hits, read misses and write misses.

From those four counts it presents the total hits and total misses. It also keeps a registered estimate of the cycles lost to misses. Each miss is charged its direction's penalty less one cycle, and the two penalties are inputs.

Accesses flagged as falling in the uncached address window are not counted. Nor is anything reported while the cache-enable input is low. A synchronous clear returns the whole unit to zero, for example when the cache itself is reset.

Top module: `cache_stat_unit`

## Requirements
- R1: An access with `acc_valid`=1, `cache_en`=1 and `acc_uncached`=0 adds one to exactly one counter at the next rising edge. The counter is picked by `acc_hit` (1 = hit, 0 = miss) and `acc_write` (1 = write, 0 = read). The other three counters keep their values.
- R2: `hit_total` always equals `rd_hit_cnt` + `wr_hit_cnt`, and `miss_total` always equals `rd_miss_cnt` + `wr_miss_cnt`. Both sums are one bit wider than a counter, so they never wrap.
- R3: After an edge without clear, `stall_est` equals rd_miss × (rd_pen − 1) + wr_miss × (wr_pen − 1). The counts and penalties used are the values present before that edge. A penalty of 0 contributes nothing.
- R4: `clr`=1 zeroes all four counters and `stall_est` at the next rising edge. An access reported in the same cycle as `clr` is dropped.
- R5: A counter at its all-ones value stays there when further matching accesses arrive. It does not wrap.
- R6: An access with `cache_en`=0 or `acc_uncached`=1 changes no counter.
- R7: `stall_est` lags the counters by one cycle. A counter change or a penalty change shows in `stall_est` one edge later.
- R8: While `rst_n` is low, all counters, both sums and `stall_est` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| clr | input | 1 | Synchronous clear of all statistics |
| cache_en | input | 1 | Cache enabled; accesses are ignored when low |
| acc_valid | input | 1 | One access reported this cycle |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_uncached | input | 1 | Access falls in the uncached window |
| rd_pen | input | PEN_W | Read miss penalty in cycles |
| wr_pen | input | PEN_W | Write miss penalty in cycles |
| rd_hit_cnt | output | CNT_W | Read hit count |
| wr_hit_cnt | output | CNT_W | Write hit count |
| rd_miss_cnt | output | CNT_W | Read miss count |
| wr_miss_cnt | output | CNT_W | Write miss count |
| hit_total | output | CNT_W+1 | Sum of hit counts |
| miss_total | output | CNT_W+1 | Sum of miss counts |
| stall_est | output | CNT_W+PEN_W+1 | Registered stall-cycle estimate |

## Verification
On every cycle the assertions check the following. At most one counter is selected. Gated accesses select none. A selected counter steps by exactly one unless saturated, and a saturated one holds. A clear zeroes counters and the stall register. An idle counter stays still. The bench's scenarios are needed for the rest: the weighted stall value and its one-cycle lag after penalty changes, the zero-penalty floor, the sums, and the full dropped-access-on-clear case across all four counters.

// File: rtl/cache_stat_pkg.sv
package cache_stat_pkg;
  // Counter slot order; the classifier indexes it as {~hit, write}.
  typedef enum logic [1:0] {
    SLOT_RD_HIT  = 2'd0,
    SLOT_WR_HIT  = 2'd1,
    SLOT_RD_MISS = 2'd2,
    SLOT_WR_MISS = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/cstat_classify.sv
module cstat_classify
  import cache_stat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cache_en,
  input  logic                 acc_valid,
  input  logic                 acc_hit,
  input  logic                 acc_write,
  input  logic                 acc_uncached,
  output logic [NUM_SLOTS-1:0] inc_vec
);
  logic  counted;
  slot_e slot;

  always_comb begin
    counted = acc_valid & cache_en & ~acc_uncached;
    slot    = slot_e'({~acc_hit, acc_write});
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
    always_comb inc_vec[g] = counted && (slot == slot_e'(g));
  end

  AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(inc_vec)); // R1
  AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cache_en || acc_uncached) |-> (inc_vec == '0)); // R6
endmodule

// File: rtl/cstat_sat_counter.sv
module cstat_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             at_max;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    at_max = (cnt_q == CNT_MAX);
    cnt_en = clr | (inc & ~at_max);
    cnt_d  = clr ? '0 : (cnt_q + CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R1
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R5
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/cstat_stall_calc.sv
module cstat_stall_calc #(
  parameter int CNT_W = 16,
  parameter int PEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [CNT_W-1:0]   rd_miss,
  input  logic [CNT_W-1:0]   wr_miss,
  input  logic [PEN_W-1:0]   rd_pen,
  input  logic [PEN_W-1:0]   wr_pen,
  output logic [CNT_W+PEN_W:0] stall
);
  localparam int STALL_W = CNT_W + PEN_W + 1;
  localparam logic [PEN_W-1:0] PEN_ONE = {{(PEN_W-1){1'b0}}, 1'b1};

  logic [PEN_W-1:0]   rd_extra;
  logic [PEN_W-1:0]   wr_extra;
  logic [STALL_W-1:0] rd_term;
  logic [STALL_W-1:0] wr_term;
  logic [STALL_W-1:0] stall_d;
  logic [STALL_W-1:0] stall_q;

  always_comb begin
    rd_extra = (rd_pen == '0) ? '0 : (rd_pen - PEN_ONE);
    wr_extra = (wr_pen == '0) ? '0 : (wr_pen - PEN_ONE);
    rd_term  = {{(STALL_W-CNT_W){1'b0}}, rd_miss} * {{(STALL_W-PEN_W){1'b0}}, rd_extra};
    wr_term  = {{(STALL_W-CNT_W){1'b0}}, wr_miss} * {{(STALL_W-PEN_W){1'b0}}, wr_extra};
    stall_d  = clr ? '0 : (rd_term + wr_term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_q <= '0;
    else        stall_q <= stall_d;
  end

  assign stall = stall_q;

  AST_STALL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (stall_q == '0)); // R4
  AST_STALL_NO_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_miss == '0 && wr_miss == '0) |=> (stall_q == '0)); // R3
endmodule

// File: rtl/cache_stat_unit.sv
module cache_stat_unit
  import cache_stat_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               cache_en,
  input  logic               acc_valid,
  input  logic               acc_hit,
  input  logic               acc_write,
  input  logic               acc_uncached,
  input  logic [PEN_W-1:0]   rd_pen,
  input  logic [PEN_W-1:0]   wr_pen,
  output logic [CNT_W-1:0]   rd_hit_cnt,
  output logic [CNT_W-1:0]   wr_hit_cnt,
  output logic [CNT_W-1:0]   rd_miss_cnt,
  output logic [CNT_W-1:0]   wr_miss_cnt,
  output logic [CNT_W:0]     hit_total,
  output logic [CNT_W:0]     miss_total,
  output logic [CNT_W+PEN_W:0] stall_est
);
  logic [NUM_SLOTS-1:0] inc_vec;
  logic [CNT_W-1:0]     cnt_arr [NUM_SLOTS];

  cstat_classify u_classify (
    .clk          (clk),
    .rst_n        (rst_n),
    .cache_en     (cache_en),
    .acc_valid    (acc_valid),
    .acc_hit      (acc_hit),
    .acc_write    (acc_write),
    .acc_uncached (acc_uncached),
    .inc_vec      (inc_vec)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cnt
    cstat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (inc_vec[g]),
      .cnt   (cnt_arr[g])
    );
  end

  cstat_stall_calc #(.CNT_W(CNT_W), .PEN_W(PEN_W)) u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .rd_miss (cnt_arr[SLOT_RD_MISS]),
    .wr_miss (cnt_arr[SLOT_WR_MISS]),
    .rd_pen  (rd_pen),
    .wr_pen  (wr_pen),
    .stall   (stall_est)
  );

  always_comb begin
    rd_hit_cnt  = cnt_arr[SLOT_RD_HIT];
    wr_hit_cnt  = cnt_arr[SLOT_WR_HIT];
    rd_miss_cnt = cnt_arr[SLOT_RD_MISS];
    wr_miss_cnt = cnt_arr[SLOT_WR_MISS];
    hit_total   = {1'b0, cnt_arr[SLOT_RD_HIT]}  + {1'b0, cnt_arr[SLOT_WR_HIT]};
    miss_total  = {1'b0, cnt_arr[SLOT_RD_MISS]} + {1'b0, cnt_arr[SLOT_WR_MISS]};
  end
endmodule

// File: tb/cache_stat_unit_tb_top.sv
module cache_stat_unit_tb_top;
  localparam int CNT_W = 8;
  localparam int PEN_W = 6;
  localparam int SW    = CNT_W + PEN_W + 1;
  localparam time CLK_PERIOD = 10ns;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n, clr, cache_en, acc_valid, acc_hit, acc_write, acc_uncached;
  logic [PEN_W-1:0] rd_pen, wr_pen;
  logic [CNT_W-1:0] rd_hit_cnt, wr_hit_cnt, rd_miss_cnt, wr_miss_cnt;
  logic [CNT_W:0]   hit_total, miss_total;
  logic [SW-1:0]    stall_est;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  longint m_rh, m_wh, m_rm, m_wm, m_stall;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache_stat_unit #(.CNT_W(CNT_W), .PEN_W(PEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cache_en(cache_en),
    .acc_valid(acc_valid), .acc_hit(acc_hit), .acc_write(acc_write),
    .acc_uncached(acc_uncached), .rd_pen(rd_pen), .wr_pen(wr_pen),
    .rd_hit_cnt(rd_hit_cnt), .wr_hit_cnt(wr_hit_cnt),
    .rd_miss_cnt(rd_miss_cnt), .wr_miss_cnt(wr_miss_cnt),
    .hit_total(hit_total), .miss_total(miss_total), .stall_est(stall_est)
  );

  function automatic longint extra(input longint p);
    return (p == 0) ? 0 : p - 1;
  endfunction

  function automatic longint sat_inc(input longint v);
    return (v == CMAX) ? v : v + 1;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " rd_hit"},  rd_hit_cnt,  m_rh);
    chk({req, " wr_hit"},  wr_hit_cnt,  m_wh);
    chk({req, " rd_miss"}, rd_miss_cnt, m_rm);
    chk({req, " wr_miss"}, wr_miss_cnt, m_wm);
    chk("R2 hit_total",  hit_total,  m_rh + m_wh);
    chk("R2 miss_total", miss_total, m_rm + m_wm);
    chk({req, "/R3/R7 stall"}, stall_est, m_stall);
  endtask

  // One cycle: drive at negedge, model the edge, compare at the next negedge.
  task automatic step(input bit v, input bit h, input bit w, input bit en,
                      input bit unc, input bit c, input string req);
    acc_valid = v; acc_hit = h; acc_write = w;
    cache_en = en; acc_uncached = unc; clr = c;
    @(posedge clk);
    m_stall = c ? 0 : m_rm * extra(rd_pen) + m_wm * extra(wr_pen);
    if (c) begin
      m_rh = 0; m_wh = 0; m_rm = 0; m_wm = 0;
    end else if (v && en && !unc) begin
      case ({h, w})
        2'b10: m_rh = sat_inc(m_rh);
        2'b11: m_wh = sat_inc(m_wh);
        2'b00: m_rm = sat_inc(m_rm);
        default: m_wm = sat_inc(m_wm);
      endcase
    end
    @(negedge clk);
    chk_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; clr = 0; cache_en = 1; acc_valid = 0; acc_hit = 0;
    acc_write = 0; acc_uncached = 0; rd_pen = 6'd5; wr_pen = 6'd3;
    m_rh = 0; m_wh = 0; m_rm = 0; m_wm = 0; m_stall = 0;
    repeat (3) @(negedge clk);
    chk_all("R8 reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 directed: one access of each kind
    step(1, 1, 0, 1, 0, 0, "R1 rd hit");
    step(1, 1, 1, 1, 0, 0, "R1 wr hit");
    step(1, 0, 0, 1, 0, 0, "R1 rd miss");
    step(1, 0, 1, 1, 0, 0, "R1 wr miss");
    step(0, 0, 0, 1, 0, 0, "R7 lag");
    // R6: gated accesses
    step(1, 0, 0, 1, 1, 0, "R6 uncached");
    step(1, 0, 1, 0, 0, 0, "R6 disabled");
    step(1, 1, 0, 0, 1, 0, "R6 both");
    // R7/R3: penalty change shows one edge later; zero penalty floor
    rd_pen = 6'd0; wr_pen = 6'd9;
    step(0, 0, 0, 1, 0, 0, "R3 pen0");
    step(0, 0, 0, 1, 0, 0, "R3 pen0 hold");
    rd_pen = 6'd1;
    step(1, 0, 0, 1, 0, 0, "R3 pen1");
    rd_pen = 6'd12;
    // R4: clear with a simultaneous access
    step(1, 0, 1, 1, 0, 1, "R4 clr drop");
    step(0, 0, 0, 1, 0, 0, "R4 after clr");

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      if ((i % 500) == 0) begin
        rd_pen = PEN_W'($urandom);
        wr_pen = PEN_W'($urandom);
      end
      step($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1, $urandom_range(0, 7) != 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 199) == 0,
           "R1 random");
    end

    // R5: saturate read misses and write hits
    step(0, 0, 0, 1, 0, 1, "R4 clr");
    for (int i = 0; i < 300; i++) step(1, 0, 0, 1, 0, 0, "R5 rd miss sat");
    for (int i = 0; i < 300; i++) step(1, 1, 1, 1, 0, 0, "R5 wr hit sat");
    step(0, 0, 0, 1, 0, 0, "R5 settled");
    step(1, 0, 1, 1, 0, 1, "R4 clr from sat");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule